// File: doc/BRIEF.md
# Effective-Address Result Unit

This execute-stage unit finishes the load-effective-address instruction. Each cycle it may accept one decoded instruction. The instruction arrives as four parts: the processor mode, the default size of the code segment, a summary of the prefixes, and the addressing operands. The addressing operands are base, scaled index and displacement. From these the unit settles two sizes, the width of the destination operand and the width of the address arithmetic. It forms the address at the address width and then fits the result to the destination width. The result may be cut down, widened with zeros, or passed through unchanged.

One cycle after acceptance, the unit presents a register write with a width code that tells the register file how to merge it. If the encoding cannot be executed, it instead presents an invalid-opcode indication. That happens when the memory operand is really a register, or when a bus-lock prefix is present. The unit has no path to the status flags.

Top module: `lea_result_unit`

## Requirements
- R1: Outputs are registered with one cycle of latency: `out_valid` equals the previous cycle's `in_valid`. Synchronous reset clears `out_valid`, `wr_en` and `invalid_op`.
- R2: An accepted instruction whose `modrm_mod` is 2'b11 (register form) produces `invalid_op`=1 and `wr_en`=0.
- R3: An accepted instruction with `pfx_lock`=1 produces `invalid_op`=1 and `wr_en`=0 in both modes.
- R4: With `mode64`=0, the address size is 32 when `cs_def32` XOR `pfx_adsize` is 1 and 16 otherwise. The operand size follows the same rule with `pfx_opsize`. `pfx_rexw` has no effect in this mode.
- R5: With `mode64`=1, the operand size is 64 when `pfx_rexw`=1, 16 when only `pfx_opsize`=1, and 32 otherwise. The address size is 32 when `pfx_adsize`=1 and 64 otherwise, never 16.
- R6: The effective address is `base_val` + (`index_val` << `scale_sel`) + sign-extended `disp_val`, taken modulo 2^address-size.
- R7: When the operand size is below the address size, only the low 16 or 32 bits of the address are written.
- R8: All bits of `wr_data` above the smaller of the two sizes are zero, so narrow addresses are zero-extended into wider destinations.
- R9: `wr_width` is 2'b00 for a 16-bit merge into the low half-word, and 2'b01 for a 32-bit write in legacy mode. It is 2'b10 for a full 64-bit write, which covers 64-bit operands and also 32-bit operands in 64-bit mode, where the upper 32 bits are written as zero.
- R10: `wr_idx` equals the `dst_idx` of the instruction that produced the write.
- R11: `wr_en` and `invalid_op` are never both 1, and both are 0 whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy/compatibility |
| cs_def32 | input | 1 | Code-segment default size is 32 bits (legacy mode) |
| pfx_opsize | input | 1 | Operand-size override prefix present |
| pfx_adsize | input | 1 | Address-size override prefix present |
| pfx_rexw | input | 1 | REX.W present |
| pfx_lock | input | 1 | Bus-lock prefix present |
| modrm_mod | input | 2 | ModRM mod field |
| dst_idx | input | RIDX_W | Destination register (ModRM.reg) |
| base_val | input | 64 | Base register value (zero if absent) |
| index_val | input | 64 | Index register value (zero if absent) |
| scale_sel | input | 2 | Index shift: 0..3 for scale 1,2,4,8 |
| disp_val | input | DISP_W | Displacement, sign-extended inside |
| out_valid | output | 1 | A result is presented |
| wr_en | output | 1 | Register write enable |
| wr_idx | output | RIDX_W | Register to write |
| wr_data | output | 64 | Value to write |
| wr_width | output | 2 | Merge code, see R9 |
| invalid_op | output | 1 | Invalid-opcode indication |

## Verification
The case hardest to reach from the ports is an address that wraps at 16 bits and is then zero-extended into a 32-bit destination. The sum must be far enough past 16'hFFFF that a missing wrap would leave visible upper bits. Directed vectors reach it with a legacy-mode instruction whose base sits just below 16'hFFFF and whose displacement is positive. Negative displacements in 64-bit mode wrap the other way. Randomized vectors then sweep every prefix combination in both modes, mixing in register-form and locked encodings, with idle gaps between some of them.

// File: rtl/lea_pkg.sv
package lea_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {
    SZ16 = 2'd0,
    SZ32 = 2'd1,
    SZ64 = 2'd2
  } size_e;

  typedef enum logic [1:0] {
    WW16 = 2'b00,
    WW32 = 2'b01,
    WW64 = 2'b10
  } wwidth_e;

  function automatic logic [XLEN-1:0] size_mask(size_e s);
    case (s)
      SZ16:    size_mask = {{(XLEN-16){1'b0}}, 16'hFFFF};
      SZ32:    size_mask = {{(XLEN-32){1'b0}}, 32'hFFFF_FFFF};
      default: size_mask = {XLEN{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/lea_size_resolve.sv
module lea_size_resolve
  import lea_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode64,
  input  logic       cs_def32,
  input  logic       pfx_opsize,
  input  logic       pfx_adsize,
  input  logic       pfx_rexw,
  input  logic       pfx_lock,
  input  logic [1:0] modrm_mod,
  output size_e      osize,
  output size_e      asize,
  output logic       illegal
);
  localparam logic [1:0] MOD_REG = 2'b11;

  always_comb begin
    if (mode64) begin
      // REX.W dominates the operand-size override
      if (pfx_rexw)        osize = SZ64;
      else if (pfx_opsize) osize = SZ16;
      else                 osize = SZ32;
      asize = pfx_adsize ? SZ32 : SZ64;
    end else begin
      osize = (cs_def32 ^ pfx_opsize) ? SZ32 : SZ16;
      asize = (cs_def32 ^ pfx_adsize) ? SZ32 : SZ16;
    end
    illegal = (modrm_mod == MOD_REG) || pfx_lock;
  end

  // R5: long mode never yields a 16-bit address
  p_no_a16_long_r5: assert property (@(posedge clk) disable iff (rst)
    mode64 |-> (asize != SZ16));
  // R4: legacy mode never yields a 64-bit operand
  p_no_o64_legacy_r4: assert property (@(posedge clk) disable iff (rst)
    !mode64 |-> (osize != SZ64));
endmodule

// File: rtl/lea_addr_calc.sv
module lea_addr_calc
  import lea_pkg::*;
#(
  parameter int DISP_W = 32
) (
  input  logic [XLEN-1:0]   base_val,
  input  logic [XLEN-1:0]   index_val,
  input  logic [1:0]        scale_sel,
  input  logic [DISP_W-1:0] disp_val,
  input  size_e             asize,
  output logic [XLEN-1:0]   ea
);
  localparam int EXT_W = XLEN - DISP_W;

  logic [XLEN-1:0] disp_x;
  logic [XLEN-1:0] scaled;
  logic [XLEN-1:0] sum;

  always_comb begin
    disp_x = {{EXT_W{disp_val[DISP_W-1]}}, disp_val};
    scaled = index_val << scale_sel;
    sum    = base_val + scaled + disp_x;
    // wrap at the address width before any widening
    ea     = sum & size_mask(asize);
  end
endmodule

// File: rtl/lea_result_unit.sv
module lea_result_unit
  import lea_pkg::*;
#(
  parameter int DISP_W = 32,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              mode64,
  input  logic              cs_def32,
  input  logic              pfx_opsize,
  input  logic              pfx_adsize,
  input  logic              pfx_rexw,
  input  logic              pfx_lock,
  input  logic [1:0]        modrm_mod,
  input  logic [RIDX_W-1:0] dst_idx,
  input  logic [63:0]       base_val,
  input  logic [63:0]       index_val,
  input  logic [1:0]        scale_sel,
  input  logic [DISP_W-1:0] disp_val,
  output logic              out_valid,
  output logic              wr_en,
  output logic [RIDX_W-1:0] wr_idx,
  output logic [63:0]       wr_data,
  output logic [1:0]        wr_width,
  output logic              invalid_op
);
  size_e           osize, asize;
  logic            illegal;
  logic [XLEN-1:0] ea;
  logic [XLEN-1:0] data_n;
  wwidth_e         width_n;

  lea_size_resolve u_size (
    .clk(clk), .rst(rst), .mode64(mode64), .cs_def32(cs_def32),
    .pfx_opsize(pfx_opsize), .pfx_adsize(pfx_adsize), .pfx_rexw(pfx_rexw),
    .pfx_lock(pfx_lock), .modrm_mod(modrm_mod),
    .osize(osize), .asize(asize), .illegal(illegal)
  );

  lea_addr_calc #(.DISP_W(DISP_W)) u_addr (
    .base_val(base_val), .index_val(index_val), .scale_sel(scale_sel),
    .disp_val(disp_val), .asize(asize), .ea(ea)
  );

  always_comb begin
    data_n = ea & size_mask(osize);
    case (osize)
      SZ16:    width_n = WW16;
      SZ32:    width_n = mode64 ? WW64 : WW32;
      default: width_n = WW64;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      wr_en      <= 1'b0;
      invalid_op <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
      wr_width   <= WW16;
    end else begin
      out_valid  <= in_valid;
      wr_en      <= in_valid & ~illegal;
      invalid_op <= in_valid & illegal;
      wr_idx     <= dst_idx;
      wr_data    <= data_n;
      wr_width   <= width_n;
    end
  end

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_lock_trap_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pfx_lock) |=> (invalid_op && !wr_en));
  p_regform_trap_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && modrm_mod == 2'b11) |=> (invalid_op && !wr_en));
  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && invalid_op) && (out_valid || (!wr_en && !invalid_op)));
  p_zext16_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_width == WW16) |-> (wr_data[63:16] == '0));
  p_zext32_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_width == WW32) |-> (wr_data[63:32] == '0));
endmodule

// File: tb/test_lea_result_unit.sv
module test_lea_result_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        mode64 = 1'b0, cs_def32 = 1'b0;
  logic        pfx_opsize = 1'b0, pfx_adsize = 1'b0, pfx_rexw = 1'b0, pfx_lock = 1'b0;
  logic [1:0]  modrm_mod = 2'b00;
  logic [3:0]  dst_idx = '0;
  logic [63:0] base_val = '0, index_val = '0;
  logic [1:0]  scale_sel = '0;
  logic [31:0] disp_val = '0;
  logic        out_valid, wr_en, invalid_op;
  logic [3:0]  wr_idx;
  logic [63:0] wr_data;
  logic [1:0]  wr_width;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // pending expectation for the result visible at the next negedge
  bit          e_have = 1'b0;
  bit          e_valid, e_wen, e_inv;
  logic [63:0] e_data;
  logic [1:0]  e_width;
  logic [3:0]  e_idx;

  always #5 clk = ~clk;

  lea_result_unit i_lea_result_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode64(mode64), .cs_def32(cs_def32),
    .pfx_opsize(pfx_opsize), .pfx_adsize(pfx_adsize), .pfx_rexw(pfx_rexw),
    .pfx_lock(pfx_lock), .modrm_mod(modrm_mod), .dst_idx(dst_idx),
    .base_val(base_val), .index_val(index_val), .scale_sel(scale_sel),
    .disp_val(disp_val), .out_valid(out_valid), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_width(wr_width), .invalid_op(invalid_op)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    if (!e_have) return;
    chk("R1 out_valid", 64'(out_valid), 64'(e_valid));
    chk("R2 R3 R11 invalid_op", 64'(invalid_op), 64'(e_inv));
    chk("R2 R3 R11 wr_en", 64'(wr_en), 64'(e_wen));
    if (e_wen) begin
      chk("R6 R7 R8 wr_data", wr_data, e_data);
      chk("R4 R5 R9 wr_width", 64'(wr_width), 64'(e_width));
      chk("R10 wr_idx", 64'(wr_idx), 64'(e_idx));
    end
  endtask

  task automatic issue(bit m, bit csd, bit op, bit ad, bit rw, bit lk, logic [1:0] md,
                       logic [3:0] dst, logic [63:0] b, logic [63:0] ix,
                       logic [1:0] sc, logic [31:0] d);
    int osz, asz;
    logic [63:0] ea;
    @(negedge clk);
    compare();
    in_valid = 1'b1; mode64 = m; cs_def32 = csd; pfx_opsize = op; pfx_adsize = ad;
    pfx_rexw = rw; pfx_lock = lk; modrm_mod = md; dst_idx = dst;
    base_val = b; index_val = ix; scale_sel = sc; disp_val = d;
    if (m) begin
      osz = rw ? 64 : (op ? 16 : 32);
      asz = ad ? 32 : 64;
    end else begin
      osz = (csd ^ op) ? 32 : 16;
      asz = (csd ^ ad) ? 32 : 16;
    end
    ea = b + ix * (64'd1 << sc) + {{32{d[31]}}, d};
    if (asz < 64) ea = ea % (64'd1 << asz);
    if (osz < 64) ea = ea % (64'd1 << osz);
    e_have  = 1'b1;
    e_valid = 1'b1;
    e_inv   = (md == 2'b11) || lk;
    e_wen   = !e_inv;
    e_data  = ea;
    e_width = (osz == 16) ? 2'b00 : ((osz == 32 && !m) ? 2'b01 : 2'b10);
    e_idx   = dst;
  endtask

  task automatic idle();
    @(negedge clk);
    compare();
    in_valid = 1'b0;
    e_have = 1'b1; e_valid = 1'b0; e_wen = 1'b0; e_inv = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset out_valid", 64'(out_valid), 64'd0);
    chk("R1 reset wr_en", 64'(wr_en), 64'd0);
    chk("R1 reset invalid_op", 64'(invalid_op), 64'd0);
    rst = 1'b0;
    idle();
    // R4 legacy 16/16
    issue(0, 0, 0, 0, 0, 0, 2'b10, 4'd1, 64'h1234, 64'h10, 2'd1, 32'h8);
    // R6 R8 16-bit wrap then zero-extend into 32-bit destination
    issue(0, 0, 1, 0, 0, 0, 2'b01, 4'd2, 64'hFFF0, 64'h0, 2'd0, 32'h20);
    // R7 legacy 32-bit address into 16-bit destination
    issue(0, 1, 1, 0, 0, 0, 2'b00, 4'd3, 64'h1234_5678, 64'h3, 2'd3, 32'h0);
    // R4 REX.W ignored in legacy
    issue(0, 1, 0, 0, 1, 0, 2'b00, 4'd4, 64'hAAAA_0000_8000_0000, 64'h1, 2'd2, 32'hFFFF_FFFC);
    // R5 R7 64-bit default: 32 operand, 64 address
    issue(1, 0, 0, 0, 0, 0, 2'b10, 4'd5, 64'hDEAD_BEEF_0000_1000, 64'h2, 2'd3, 32'h40);
    // R5 REX.W beats 66H
    issue(1, 0, 1, 0, 1, 0, 2'b10, 4'd6, 64'hDEAD_BEEF_0000_1000, 64'h2, 2'd3, 32'h40);
    // R5 16-bit operand, 64-bit address
    issue(1, 0, 1, 0, 0, 0, 2'b01, 4'd7, 64'h0123_4567_89AB_CDEF, 64'h0, 2'd0, 32'h1);
    // R8 32-bit address zero-extended into 64
    issue(1, 0, 0, 1, 1, 0, 2'b01, 4'd8, 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 2'd0, 32'h20);
    // R6 negative displacement wrap at 64 bits
    issue(1, 0, 0, 0, 1, 0, 2'b01, 4'd9, 64'h0, 64'h0, 2'd0, 32'hFFFF_FFF8);
    // R2 register form
    issue(1, 0, 0, 0, 1, 0, 2'b11, 4'd10, 64'h5, 64'h0, 2'd0, 32'h0);
    // R3 lock in both modes
    issue(0, 1, 0, 0, 0, 1, 2'b00, 4'd11, 64'h5, 64'h0, 2'd0, 32'h0);
    issue(1, 0, 0, 0, 0, 1, 2'b10, 4'd12, 64'h5, 64'h0, 2'd0, 32'h0);
    idle();
    idle();
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[31:29] == 3'd0) idle();
      else issue(r[0], r[1], r[2], r[3], r[4], (r[9:5] == 5'd0), r[11:10], r[15:12],
                 {$urandom, $urandom}, {$urandom, $urandom}, r[17:16], $urandom);
    end
    idle();
    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule